// File: doc/BRIEF.md
# EEPROM Page Buffer and Program-Cycle Controller

This block sits between a two-wire serial slave protocol engine and a nonvolatile memory array. Once the protocol engine has decoded a write command, it presents the target byte address. The block then gathers the data bytes that follow into a one-row page latch. It tells the engine, byte by byte, whether each byte is accepted. If the command is closed correctly, the block commits the whole row in a single self-timed program cycle.

A row is a group of `PAGE` consecutive bytes whose upper address bits match. Inside a transfer only the low in-row address bits advance, so a burst that runs past the end of a row wraps back to the start of that same row. The commit happens only when the engine signals a STOP that landed right after an acknowledge slot. An abort, or any other ending, throws the latched bytes away. A write-control level that was high during the command preamble blocks the whole transfer. While the program cycle runs, the block reports busy and ignores every command. When the cycle ends, it leaves its address counter pointing just past the last byte written, ready for a current-address read.

Top module: `eeprom_page_commit`

## Requirements
- R1: After reset, `busy`, `byte_ack` and `arr_we` are 0 and `cur_addr` is 0.
- R2: With write-control low for the whole preamble, every `byte_vld` strobe in the data phase is answered by `byte_ack` = 1 in the next clock cycle.
- R3: Each accepted byte advances only the low 7 bits of the byte address (bits 6..0). Bits 16..7 hold the row, so the byte after in-row offset 127 goes to offset 0 of the same row.
- R4: A `stop_ack` strobe after at least one accepted byte starts a program cycle. An `abort_cmd` strobe discards the latched bytes, and no program cycle and no array write follow.
- R5: If `wc_lvl` is high in any clock cycle from the `cmd_start` strobe through the `addr_ld` strobe (both included), every data byte is refused (`byte_ack` = 0 in the cycle after the strobe) and `stop_ack` starts no program cycle. A high `wc_lvl` after `addr_ld` has no effect.
- R6: `busy` rises in the cycle after the committing `stop_ack` and stays high for exactly `TPROG` clock cycles.
- R7: During `busy`, each received in-row offset is written exactly once, in ascending offset order from 0 to 127, with `arr_addr` = {row, offset} and the latched data. Offsets that were not received are not written.
- R8: When one transfer delivers more than 128 bytes, a later byte that lands on an already used offset replaces the earlier one, and only the last value is written.
- R9: While `busy` is high, `cmd_start`, `addr_ld`, `byte_vld`, `stop_ack` and `abort_cmd` are ignored. `byte_ack` stays 0 and `cur_addr` keeps its value.
- R10: `cur_addr` shows `addr_in` after `addr_ld`, advances with each accepted byte under the rule of R3, and after a program cycle points one past the last written location.
- R11: A transfer of exactly one data byte closed by `stop_ack` commits exactly one array write.
- R12: A `stop_ack` with no accepted byte starts no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Strobe: START of a command, opens the write-control window |
| addr_ld | input | 1 | Strobe: full byte address available, closes the window |
| addr_in | input | AW | Byte address loaded by `addr_ld` |
| byte_vld | input | 1 | Strobe: one data byte received |
| byte_in | input | 8 | Data byte qualified by `byte_vld` |
| stop_ack | input | 1 | Strobe: STOP seen directly after an acknowledge slot |
| abort_cmd | input | 1 | Strobe: transfer ended in any other way |
| wc_lvl | input | 1 | Write-control level, high inhibits writing |
| busy | output | 1 | Program cycle in progress |
| byte_ack | output | 1 | Accept (1) or refuse (0) for the byte strobed one cycle earlier |
| arr_we | output | 1 | Array write enable, one per written byte |
| arr_addr | output | AW | Array write address |
| arr_data | output | 8 | Array write data |
| cur_addr | output | AW | Internal address counter |

## Verification
Directed transfers cover the following cases:
- A single-byte write.
- A full 128-byte row started in mid-row, which shows that the wrap lands on offset 0 of the same row and not on the next row.
- A 5-byte burst straddling the row end.
- A 140-byte burst, which separates a last-wins latch from one that keeps the first value.

Write-control is raised in turn at the START cycle, inside the window and at the address strobe, which shows that the whole preamble is sampled. It is then raised only after the address, which shows that it is ignored there. Abort endings, empty STOPs and commands poked in while busy each confirm that no spurious program cycle or address change takes place. Seeded random transfers mix lengths, start offsets, endings and write-control levels, and are checked against a bench model of the page latch.

// File: rtl/eeprom_page_commit.sv
module eeprom_page_commit #(
  parameter int AW    = 17,
  parameter int PAGE  = 128,
  parameter int TPROG = 1250000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_start,
  input  logic          addr_ld,
  input  logic [AW-1:0] addr_in,
  input  logic          byte_vld,
  input  logic [7:0]    byte_in,
  input  logic          stop_ack,
  input  logic          abort_cmd,
  input  logic          wc_lvl,
  output logic          busy,
  output logic          byte_ack,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [7:0]    arr_data,
  output logic [AW-1:0] cur_addr
);
  localparam int PW = $clog2(PAGE);
  localparam int RW = AW - PW;
  localparam int CW = $clog2(TPROG + PAGE + 1);

  typedef enum logic [1:0] {S_IDLE, S_COLL, S_PROG} st_t;

  st_t            st;
  logic [RW-1:0]  row;
  logic [PW-1:0]  ptr;
  logic [PAGE-1:0] valid;
  logic [7:0]     page [PAGE];
  logic           win, wc_seen, prot;
  logic [CW-1:0]  cnt;
  logic [PW-1:0]  slot;
  logic           take;

  assign busy     = (st == S_PROG);
  assign slot     = cnt[PW-1:0];
  assign take     = (st == S_COLL) && byte_vld && !prot && !addr_ld && !cmd_start;
  assign arr_we   = busy && (cnt < CW'(PAGE)) && valid[slot];
  assign arr_addr = {row, slot};
  assign arr_data = page[slot];
  assign cur_addr = {row, ptr};

  always_ff @(posedge clk) begin
    if (take) page[ptr] <= byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      row      <= '0;
      ptr      <= '0;
      valid    <= '0;
      win      <= 1'b0;
      wc_seen  <= 1'b0;
      prot     <= 1'b0;
      cnt      <= '0;
      byte_ack <= 1'b0;
    end else begin
      byte_ack <= 1'b0;
      if (st == S_PROG) begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(TPROG - 1)) begin
          st    <= S_IDLE;
          valid <= '0;
        end
      end else if (cmd_start) begin
        st      <= S_IDLE;
        win     <= 1'b1;
        wc_seen <= wc_lvl;
        valid   <= '0;
      end else if (addr_ld) begin
        st    <= S_COLL;
        row   <= addr_in[AW-1:PW];
        ptr   <= addr_in[PW-1:0];
        prot  <= (win & wc_seen) | wc_lvl;
        win   <= 1'b0;
        valid <= '0;
      end else begin
        if (win) wc_seen <= wc_seen | wc_lvl;
        if (st == S_COLL) begin
          if (byte_vld) begin
            byte_ack <= !prot;
            if (!prot) begin
              valid[ptr] <= 1'b1;
              ptr        <= ptr + 1'b1;
            end
          end
          if (stop_ack) begin
            cnt <= '0;
            st  <= (!prot && |valid) ? S_PROG : S_IDLE;
          end else if (abort_cmd) begin
            st    <= S_IDLE;
            valid <= '0;
          end
        end
      end
    end
  end

  assert_we_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !byte_ack);

  assert_busy_from_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ack));

  assert_row_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(arr_addr[AW-1:PW]));

  assert_ack_from_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ack |-> $past(byte_vld));

  assert_slot_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we) && $past(busy)) |-> (arr_addr[PW-1:0] > $past(arr_addr[PW-1:0])));

  assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_addr));
endmodule

// File: tb/eeprom_page_commit_tb.sv
module eeprom_page_commit_tb;
  localparam int AW = 17, PAGE = 128, TPROG = 200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, addr_ld = 0, byte_vld = 0, stop_ack = 0, abort_cmd = 0, wc_lvl = 0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] byte_in = '0;
  logic busy, byte_ack, arr_we;
  logic [AW-1:0] arr_addr, cur_addr;
  logic [7:0] arr_data;

  int n_run = 0, n_fail = 0;
  logic [7:0] ep [PAGE];
  bit ev [PAGE];
  logic [AW-1:0] wa [256];
  logic [7:0] wd [256];

  always #4 clk = ~clk;

  eeprom_page_commit #(.AW(AW), .PAGE(PAGE), .TPROG(TPROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .addr_ld(addr_ld), .addr_in(addr_in),
    .byte_vld(byte_vld), .byte_in(byte_in), .stop_ack(stop_ack), .abort_cmd(abort_cmd),
    .wc_lvl(wc_lvl), .busy(busy), .byte_ack(byte_ack), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_data(arr_data), .cur_addr(cur_addr));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return {a[AW-1:7], 7'(a[6:0] + 7'd1)};
  endfunction

  task automatic txn(input logic [AW-1:0] a, input int n, input bit wc_s, input bit wc_w,
                     input bit wc_l, input bit wc_after, input bit commit, input bit poke,
                     input string req);
    bit prot;
    int acc, cyc, wi, k;
    logic [AW-1:0] ea;
    logic [7:0] d;
    bit exp_busy;
    prot = wc_s | wc_w | wc_l;
    for (int s = 0; s < PAGE; s++) ev[s] = 0;
    @(negedge clk); cmd_start = 1; wc_lvl = wc_s;
    @(negedge clk); cmd_start = 0; wc_lvl = wc_w;
    @(negedge clk); addr_ld = 1; addr_in = a; wc_lvl = wc_l;
    @(negedge clk); addr_ld = 0; wc_lvl = wc_after;
    chk(cur_addr == a, {req, " R10 addr load"}, cur_addr, a);
    ea = a; acc = 0;
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      byte_vld = 1; byte_in = d;
      @(negedge clk); byte_vld = 0;
      chk(byte_ack == !prot, {req, prot ? " R5 refuse" : " R2 accept"}, byte_ack, !prot);
      if (!prot) begin
        ep[ea[6:0]] = d; ev[ea[6:0]] = 1; ea = next_addr(ea); acc++;
      end
    end
    if (commit) stop_ack = 1; else abort_cmd = 1;
    @(negedge clk); stop_ack = 0; abort_cmd = 0; wc_lvl = 0;
    exp_busy = commit && acc > 0;
    chk(busy == exp_busy, {req, " R4/R5/R12 busy start"}, busy, exp_busy);
    cyc = 0; wi = 0;
    while (busy && cyc < TPROG + 20) begin
      if (arr_we && wi < 256) begin wa[wi] = arr_addr; wd[wi] = arr_data; wi++; end
      if (poke && cyc == PAGE + 5) begin
        cmd_start = 1; addr_ld = 1; addr_in = ~a; byte_vld = 1; abort_cmd = 1;
      end
      if (poke && cyc == PAGE + 6) begin
        cmd_start = 0; addr_ld = 0; byte_vld = 0; abort_cmd = 0;
        chk(byte_ack == 0, {req, " R9 no ack while busy"}, byte_ack, 0);
        chk(cur_addr == ea, {req, " R9 addr held while busy"}, cur_addr, ea);
      end
      cyc++;
      @(negedge clk);
    end
    if (exp_busy) begin
      chk(cyc == TPROG, {req, " R6 busy length"}, cyc, TPROG);
      k = 0;
      for (int s = 0; s < PAGE; s++) if (ev[s]) begin
        if (k < wi) begin
          chk(wa[k] == {a[AW-1:7], 7'(s)}, {req, " R7 write addr"}, wa[k], {a[AW-1:7], 7'(s)});
          chk(wd[k] == ep[s], {req, " R7/R8 write data"}, wd[k], ep[s]);
        end
        k++;
      end
      chk(wi == k, {req, " R7 write count"}, wi, k);
    end else begin
      chk(arr_we == 0 && wi == 0, {req, " R4 no writes"}, wi, 0);
    end
    chk(cur_addr == ea, {req, " R10 final addr"}, cur_addr, ea);
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(busy == 0 && byte_ack == 0 && arr_we == 0, "R1 reset outputs", {busy, byte_ack, arr_we}, 0);
    chk(cur_addr == 0, "R1 reset addr", cur_addr, 0);
    rst_n = 1;
    @(negedge clk);
    txn(17'h12345, 1,   0, 0, 0, 0, 1, 0, "R11 byte write");
    txn(17'h0A0C0, 128, 0, 0, 0, 0, 1, 0, "R3 full row mid start");
    txn(17'h1FF7E, 5,   0, 0, 0, 0, 1, 0, "R3 row end wrap");
    txn(17'h04410, 140, 0, 0, 0, 0, 1, 0, "R8 last wins");
    txn(17'h00321, 4,   0, 0, 0, 0, 0, 0, "R4 abort");
    txn(17'h00400, 3,   1, 0, 0, 0, 1, 0, "R5 wc at start");
    txn(17'h00500, 3,   0, 1, 0, 0, 1, 0, "R5 wc in window");
    txn(17'h00600, 3,   0, 0, 1, 0, 1, 0, "R5 wc at addr");
    txn(17'h00700, 6,   0, 0, 0, 1, 1, 0, "R5 wc after window");
    txn(17'h1357F, 9,   0, 0, 0, 0, 1, 1, "R9 poke while busy");
    txn(17'h08000, 0,   0, 0, 0, 0, 1, 0, "R12 empty stop");
    for (int t = 0; t < 16; t++) begin
      logic [AW-1:0] ra;
      int rn;
      ra = AW'($urandom);
      rn = $urandom % 151;
      txn(ra, rn, ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
          1'($urandom), ($urandom % 5) != 0, 0, "R2/R3/R7 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule